// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Control

This block turns characters into asynchronous serial frames on a single output line. A processor-style write strobe drops a character into a one-entry holding register. At the next frame boundary the character moves into a shift register and goes out as a frame:

- a low start bit;
- five to eight data bits, least significant first;
- an optional even or odd parity bit;
- one or two high stop bits.

Bit timing comes entirely from a `bit_tick` pulse that marks the start of each bit period. Baud generation lies outside the block.

Single-cycle command pulses control the transmitter:

- enable, disable and abort it;
- start and stop a break (a continuous low level);
- raise the request-to-send output.

An optional clear-to-send gate holds back new frames. An optional automatic mode lowers request-to-send once a disabled transmitter has drained. Two flags report progress: `thr_ready` tells software when the holding register can take another character, and `tx_empty` tells it when the line is fully idle.

Top module: `sertx_flow`

## Requirements
- R1: A frame is a 0 start bit, then `5 + cfg_len` data bits least significant first, then a parity bit when `cfg_par` is 1 (even: the bit makes the count of ones over data and parity even) or 2 (odd), then one stop bit of 1, plus a second one when `cfg_stop2` is 1; `cfg_par` 0 or 3 means no parity bit. Configuration is taken when the frame starts.
- R2: When no frame is in flight and the holding register is empty, `txd` is 1 and `tx_empty` is 1; `thr_ready` is 1 whenever the holding register is empty.
- R3: The cycle after a write, `tx_empty` and `thr_ready` are 0. A character written while a frame is in flight starts with the start bit in the bit period right after the last stop bit, with no idle bit in between.
- R4: A disable command lets the frame in flight finish unchanged; while disabled, no new frame starts and a pending character stays in the holding register.
- R5: A reset command returns `txd` to 1 in the next cycle, abandons the frame in flight, empties the holding register and leaves the transmitter disabled until an enable command.
- R6: With `cfg_cts_en` set, a frame starts only on a tick where `cts` is 1; `cts` falling during a frame does not affect that frame.
- R7: A break-start command drives `txd` to 0 from the next cycle and holds it there across bit ticks, whatever `cts` is; a frame in flight is abandoned.
- R8: After a break-stop command, `txd` returns to 1 on a bit tick at least one full bit period after the break began. A pending character then starts no earlier than the following tick, so at least one bit of mark precedes it.
- R9: A request-to-send command sets `rts` to 1 in the next cycle. With `cfg_auto_rts` set and the transmitter disabled, `rts` falls on the second tick after the last stop bit began, which is one bit period after that stop bit ends.
- R10: While `rst_n` is low, `txd` is 1, `rts` is 0, `tx_empty` is 1 and `thr_ready` is 1.
- R11: `txd` changes only on a clock edge with `bit_tick` high, except in the cycle after a reset or break-start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse at each bit period boundary |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_MAX | Character to transmit |
| cmd_enable | input | 1 | Enable the transmitter |
| cmd_disable | input | 1 | Disable after the current frame |
| cmd_reset | input | 1 | Abort the frame, flush the holding register, disable |
| cmd_brk_start | input | 1 | Begin a break |
| cmd_brk_stop | input | 1 | End the break |
| cmd_rts_on | input | 1 | Assert request-to-send |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_cts_en | input | 1 | Gate frame starts on clear-to-send |
| cfg_auto_rts | input | 1 | Drop request-to-send after a disabled drain |
| cts | input | 1 | Clear-to-send, 1 means asserted |
| txd | output | 1 | Serial data, 1 is mark |
| rts | output | 1 | Request-to-send, 1 means asserted |
| tx_empty | output | 1 | No frame in flight and holding register empty |
| thr_ready | output | 1 | Holding register can accept a character |

## Verification
The properties assume that every command, the write strobe and `bit_tick` are single-cycle pulses synchronous to `clk`. They also assume that `cts` and the configuration inputs change only between clock edges. The bench drives all inputs on the falling edge and issues each command for exactly one cycle. It produces a tick every fourth cycle and changes configuration only while the transmitter is empty, so every frame sees the settings its expected pattern was computed from.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_START = 3'd1,
    FR_DATA  = 3'd2,
    FR_PAR   = 3'd3,
    FR_STOP  = 3'd4
  } fr_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

endpackage

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic          flush,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q, full_n;
  logic [DW-1:0] data_q;
  logic          data_en;

  always_comb begin
    data_en = wr_stb & ~flush;
    if (flush)       full_n = 1'b0;
    else if (wr_stb) full_n = 1'b1;
    else if (take)   full_n = 1'b0;
    else             full_n = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sertx_frame.sv
`timescale 1ns/1ps
module sertx_frame
  import sertx_pkg::*;
#(
  parameter  int DATA_MIN = 5,
  parameter  int DATA_MAX = 8,
  localparam int LEN_W    = $clog2(DATA_MAX - DATA_MIN + 1),
  localparam int CNT_W    = $clog2(DATA_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                abort,
  input  logic                go_ok,
  input  logic                hold_full,
  input  logic [DATA_MAX-1:0] hold_data,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  output logic                launch,
  output logic                idle,
  output logic                txd_raw
);

  fr_state_e           st_q, st_n;
  logic [DATA_MAX-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n, last_q, last_n;
  logic                par_en_q, par_en_n, par_bit_q, par_bit_n;
  logic                stop2_q, stop2_n, scnt_q, scnt_n;
  logic [CNT_W-1:0]    cfg_last;
  logic [DATA_MAX-1:0] masked;
  logic                par_xor, last_stop, fr_en;

  // parity over only the configured data bits
  always_comb begin
    cfg_last = CNT_W'(DATA_MIN - 1) + CNT_W'(cfg_len);
    for (int i = 0; i < DATA_MAX; i++) begin
      masked[i] = hold_data[i] & (CNT_W'(i) <= cfg_last);
    end
    par_xor = ^masked;
  end

  always_comb begin
    last_stop = (st_q == FR_STOP) && (scnt_q == stop2_q);
    launch    = tick && !abort && go_ok && hold_full &&
                ((st_q == FR_IDLE) || last_stop);
    fr_en     = tick | abort;
  end

  always_comb begin
    st_n      = st_q;
    sh_n      = sh_q;
    cnt_n     = cnt_q;
    last_n    = last_q;
    par_en_n  = par_en_q;
    par_bit_n = par_bit_q;
    stop2_n   = stop2_q;
    scnt_n    = scnt_q;
    if (abort) begin
      st_n = FR_IDLE;
    end else if (launch) begin
      st_n      = FR_START;
      sh_n      = hold_data;
      last_n    = cfg_last;
      par_en_n  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
      par_bit_n = (cfg_par == PAR_ODD) ? ~par_xor : par_xor;
      stop2_n   = cfg_stop2;
    end else if (tick) begin
      case (st_q)
        FR_START: begin
          st_n  = FR_DATA;
          cnt_n = '0;
        end
        FR_DATA: begin
          sh_n = sh_q >> 1;
          if (cnt_q == last_q) begin
            st_n   = par_en_q ? FR_PAR : FR_STOP;
            scnt_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        FR_PAR: begin
          st_n   = FR_STOP;
          scnt_n = 1'b0;
        end
        FR_STOP: begin
          if (last_stop) st_n = FR_IDLE;
          else           scnt_n = 1'b1;
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FR_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      last_q    <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop2_q   <= 1'b0;
      scnt_q    <= 1'b0;
    end else if (fr_en) begin
      st_q      <= st_n;
      sh_q      <= sh_n;
      cnt_q     <= cnt_n;
      last_q    <= last_n;
      par_en_q  <= par_en_n;
      par_bit_q <= par_bit_n;
      stop2_q   <= stop2_n;
      scnt_q    <= scnt_n;
    end
  end

  always_comb begin
    case (st_q)
      FR_START: txd_raw = 1'b0;
      FR_DATA:  txd_raw = sh_q[0];
      FR_PAR:   txd_raw = par_bit_q;
      default:  txd_raw = 1'b1;
    endcase
    idle = (st_q == FR_IDLE);
  end

endmodule

// File: rtl/sertx_ctrl.sv
`timescale 1ns/1ps
module sertx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic cmd_reset,
  input  logic cmd_brk_start,
  input  logic cmd_brk_stop,
  input  logic cmd_rts_on,
  input  logic cfg_auto_rts,
  input  logic frame_idle,
  output logic enabled,
  output logic brk_active,
  output logic rts,
  output logic abort
);

  logic en_q, en_n;
  logic brk_q, brk_n, brk_tk_q, brk_tk_n, brk_sp_q, brk_sp_n;
  logic rts_q, rts_n;

  always_comb begin
    if (cmd_reset || cmd_disable) en_n = 1'b0;
    else if (cmd_enable)          en_n = 1'b1;
    else                          en_n = en_q;
  end

  always_comb begin
    brk_n    = brk_q;
    brk_tk_n = brk_tk_q;
    brk_sp_n = brk_sp_q;
    if (cmd_reset) begin
      brk_n    = 1'b0;
      brk_tk_n = 1'b0;
      brk_sp_n = 1'b0;
    end else if (cmd_brk_start) begin
      brk_n    = 1'b1;
      brk_tk_n = 1'b0;
      brk_sp_n = 1'b0;
    end else if (brk_q) begin
      if (tick && brk_sp_q && brk_tk_q) begin
        brk_n    = 1'b0;
        brk_tk_n = 1'b0;
        brk_sp_n = 1'b0;
      end else begin
        if (tick)         brk_tk_n = 1'b1;
        if (cmd_brk_stop) brk_sp_n = 1'b1;
      end
    end
  end

  always_comb begin
    if (cmd_rts_on)
      rts_n = 1'b1;
    else if (tick && cfg_auto_rts && !en_q && frame_idle && !brk_q)
      rts_n = 1'b0;
    else
      rts_n = rts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      brk_q    <= 1'b0;
      brk_tk_q <= 1'b0;
      brk_sp_q <= 1'b0;
      rts_q    <= 1'b0;
    end else begin
      en_q     <= en_n;
      brk_q    <= brk_n;
      brk_tk_q <= brk_tk_n;
      brk_sp_q <= brk_sp_n;
      rts_q    <= rts_n;
    end
  end

  assign enabled    = en_q;
  assign brk_active = brk_q;
  assign rts        = rts_q;
  assign abort      = cmd_reset | cmd_brk_start;

endmodule

// File: rtl/sertx_flow.sv
`timescale 1ns/1ps
module sertx_flow #(
  parameter  int DATA_MIN = 5,
  parameter  int DATA_MAX = 8,
  localparam int LEN_W    = $clog2(DATA_MAX - DATA_MIN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                wr_stb,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                cmd_enable,
  input  logic                cmd_disable,
  input  logic                cmd_reset,
  input  logic                cmd_brk_start,
  input  logic                cmd_brk_stop,
  input  logic                cmd_rts_on,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                cfg_cts_en,
  input  logic                cfg_auto_rts,
  input  logic                cts,
  output logic                txd,
  output logic                rts,
  output logic                tx_empty,
  output logic                thr_ready
);

  logic                enabled, brk_active, abort;
  logic                launch, frame_idle, txd_raw, go_ok;
  logic                hold_full;
  logic [DATA_MAX-1:0] hold_data;

  assign go_ok = enabled && !brk_active && (!cfg_cts_en || cts);

  sertx_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (bit_tick),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .cmd_reset    (cmd_reset),
    .cmd_brk_start(cmd_brk_start),
    .cmd_brk_stop (cmd_brk_stop),
    .cmd_rts_on   (cmd_rts_on),
    .cfg_auto_rts (cfg_auto_rts),
    .frame_idle   (frame_idle),
    .enabled      (enabled),
    .brk_active   (brk_active),
    .rts          (rts),
    .abort        (abort)
  );

  sertx_hold #(.DW(DATA_MAX)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .take   (launch),
    .flush  (cmd_reset),
    .full   (hold_full),
    .data   (hold_data)
  );

  sertx_frame #(.DATA_MIN(DATA_MIN), .DATA_MAX(DATA_MAX)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .abort    (abort),
    .go_ok    (go_ok),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .cfg_len  (cfg_len),
    .cfg_par  (cfg_par),
    .cfg_stop2(cfg_stop2),
    .launch   (launch),
    .idle     (frame_idle),
    .txd_raw  (txd_raw)
  );

  assign txd       = brk_active ? 1'b0 : txd_raw;
  assign tx_empty  = frame_idle && !hold_full;
  assign thr_ready = !hold_full;

endmodule

// File: rtl/sertx_flow_chk.sv
`timescale 1ns/1ps
module sertx_flow_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_stb,
  input logic cmd_reset,
  input logic cmd_brk_start,
  input logic cfg_cts_en,
  input logic cts,
  input logic txd,
  input logic rts,
  input logic tx_empty,
  input logic thr_ready,
  input logic enabled,
  input logic brk_active,
  input logic launch
);

  assert_idle_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !brk_active |-> txd);

  assert_empty_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_ready);

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !cmd_reset |=> !tx_empty && !thr_ready);

  assert_start_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> enabled);

  assert_reset_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> txd && tx_empty && !enabled);

  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cfg_cts_en |-> cts);

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> !txd);

  assert_break_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_brk_start && !cmd_reset |=> !txd);

  assert_rts_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(bit_tick) && !$past(enabled));

  assert_tick_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick && !cmd_reset && !cmd_brk_start |=> $stable(txd));

endmodule

bind sertx_flow sertx_flow_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .wr_stb       (wr_stb),
  .cmd_reset    (cmd_reset),
  .cmd_brk_start(cmd_brk_start),
  .cfg_cts_en   (cfg_cts_en),
  .cts          (cts),
  .txd          (txd),
  .rts          (rts),
  .tx_empty     (tx_empty),
  .thr_ready    (thr_ready),
  .enabled      (enabled),
  .brk_active   (brk_active),
  .launch       (launch)
);

// File: tb/sertx_flow_tb.sv
`timescale 1ns/1ps
module sertx_flow_tb;

  localparam int DIV   = 4;
  localparam int LOG_N = 4096;
  localparam int C_EN = 0, C_DIS = 1, C_RST = 2, C_BRK = 3, C_BRKSTOP = 4, C_RTS = 5;

  logic       clk, rst_n, bit_tick, wr_stb;
  logic [7:0] wr_data;
  logic       cmd_enable, cmd_disable, cmd_reset, cmd_brk_start, cmd_brk_stop, cmd_rts_on;
  logic [1:0] cfg_len, cfg_par;
  logic       cfg_stop2, cfg_cts_en, cfg_auto_rts, cts;
  logic       txd, rts, tx_empty, thr_ready;

  int   tests, fails, log_n, glitches, div_cnt;
  bit   done;
  logic txd_log [LOG_N];
  logic rts_log [LOG_N];
  logic txd_prev;

  sertx_flow u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
    .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop), .cmd_rts_on(cmd_rts_on),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_cts_en(cfg_cts_en),
    .cfg_auto_rts(cfg_auto_rts), .cts(cts), .txd(txd), .rts(rts), .tx_empty(tx_empty),
    .thr_ready(thr_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // tick generator, driven on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      div_cnt  = 0;
      bit_tick = 1'b0;
    end else begin
      bit_tick = (div_cnt == DIV - 1);
      div_cnt  = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    end
  end

  // per-bit log taken 1 ns after each rising edge
  always @(posedge clk) begin
    logic t, c;
    t = bit_tick;
    c = cmd_reset | cmd_brk_start;
    #1;
    if (rst_n) begin
      if (t && log_n < LOG_N) begin
        txd_log[log_n] = txd;
        rts_log[log_n] = rts;
        log_n++;
      end
      if (!t && !c && txd !== txd_prev) glitches++;
    end
    txd_prev = txd;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input int which);
    case (which)
      C_EN:      cmd_enable    = 1'b1;
      C_DIS:     cmd_disable   = 1'b1;
      C_RST:     cmd_reset     = 1'b1;
      C_BRK:     cmd_brk_start = 1'b1;
      C_BRKSTOP: cmd_brk_stop  = 1'b1;
      default:   cmd_rts_on    = 1'b1;
    endcase
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
    cmd_brk_start = 0; cmd_brk_stop = 0; cmd_rts_on = 0;
  endtask

  task automatic write_char(input logic [7:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = log_n + n;
    while (log_n < target) @(negedge clk);
  endtask

  task automatic wait_empty();
    int g;
    g = 0;
    while (!tx_empty && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_txd(input logic v);
    int g;
    g = 0;
    while (txd !== v && g < 400) begin @(negedge clk); g++; end
  endtask

  task automatic wait_ready();
    int g;
    g = 0;
    while (!thr_ready && g < 400) begin @(negedge clk); g++; end
  endtask

  function automatic int count_val(input int from, input logic v);
    int n;
    n = 0;
    for (int i = from; i < log_n; i++) if (txd_log[i] === v) n++;
    return n;
  endfunction

  function automatic int frame_len(input int len, input int pm, input int s2);
    return 1 + (5 + len) + ((pm == 1 || pm == 2) ? 1 : 0) + 1 + s2;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [7:0] d, input int len, input int pm, input int s2);
    logic [15:0] v;
    int k;
    logic p;
    v = '0; k = 1; p = 1'b0;
    for (int i = 0; i < 5 + len; i++) begin v[k] = d[i]; p = p ^ d[i]; k++; end
    if (pm == 1) begin v[k] = p;  k++; end
    if (pm == 2) begin v[k] = ~p; k++; end
    v[k] = 1'b1; k++;
    if (s2 != 0) v[k] = 1'b1;
    return v;
  endfunction

  task automatic check_frame(input int from, input logic [7:0] d, input int len, input int pm,
                             input int s2, input string req, output int start, output int nxt);
    int s, l;
    logic [15:0] act;
    s = from;
    while (s < log_n && txd_log[s] !== 1'b0) s++;
    l = frame_len(len, pm, s2);
    act = '0;
    if (s + l > log_n) begin
      chk(req, "frame not found", s, from);
    end else begin
      for (int k = 0; k < l; k++) act[k] = txd_log[s + k];
      chk(req, "frame bits", int'(act), int'(exp_frame(d, len, pm, s2)));
    end
    start = s;
    nxt   = s + l;
  endtask

  task automatic test_reset_state();
    chk("R10", "txd", int'(txd), 1);
    chk("R10", "rts", int'(rts), 0);
    chk("R10", "tx_empty", int'(tx_empty), 1);
    chk("R10", "thr_ready", int'(thr_ready), 1);
  endtask

  task automatic test_frame(input logic [7:0] d, input int len, input int pm, input int s2);
    int m, s, e;
    cfg_len = 2'(len); cfg_par = 2'(pm); cfg_stop2 = s2[0];
    m = log_n;
    write_char(d);
    chk("R3", "tx_empty after write", int'(tx_empty), 0);
    chk("R3", "thr_ready after write", int'(thr_ready), 0);
    wait_empty();
    wait_ticks(2);
    check_frame(m, d, len, pm, s2, "R1", s, e);
    chk("R2", "idle txd", int'(txd), 1);
    chk("R2", "idle tx_empty", int'(tx_empty), 1);
  endtask

  task automatic test_back_to_back();
    int m, s1, e1, s2, e2;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0;
    m = log_n;
    write_char(8'h4B);
    wait_ready();
    chk("R2", "busy while sending", int'(tx_empty), 0);
    write_char(8'hE1);
    wait_empty();
    wait_ticks(2);
    check_frame(m, 8'h4B, 3, 0, 0, "R3", s1, e1);
    check_frame(e1, 8'hE1, 3, 0, 0, "R3", s2, e2);
    chk("R3", "no gap between frames", s2, e1);
  endtask

  task automatic test_soft_reset();
    int m, s, e;
    write_char(8'h00);
    wait_ready();
    write_char(8'h55);
    wait_ticks(2);
    chk("R5", "low mid-frame", int'(txd), 0);
    cmd(C_RST);
    chk("R5", "txd after reset", int'(txd), 1);
    chk("R5", "holding flushed", int'(thr_ready), 1);
    chk("R5", "empty after reset", int'(tx_empty), 1);
    m = log_n;
    write_char(8'h7E);
    wait_ticks(6);
    chk("R5", "no start while reset", count_val(m, 1'b0), 0);
    cmd(C_EN);
    wait_empty();
    wait_ticks(2);
    check_frame(m, 8'h7E, 3, 0, 0, "R5", s, e);
  endtask

  task automatic test_disable_rts();
    int m, s, e, m2;
    cfg_auto_rts = 1'b1;
    cmd(C_RTS);
    chk("R9", "rts asserted", int'(rts), 1);
    m = log_n;
    write_char(8'h96);
    wait_ticks(3);
    cmd(C_DIS);
    wait_empty();
    wait_ticks(3);
    check_frame(m, 8'h96, 3, 0, 0, "R4", s, e);
    chk("R9", "rts held at frame end", int'(rts_log[e]), 1);
    chk("R9", "rts dropped one bit later", int'(rts_log[e + 1]), 0);
    m2 = log_n;
    write_char(8'h11);
    wait_ticks(6);
    chk("R4", "no start while disabled", count_val(m2, 1'b0), 0);
    chk("R4", "character still pending", int'(tx_empty), 0);
    cfg_auto_rts = 1'b0;
    cmd(C_EN);
    wait_empty();
    wait_ticks(2);
    check_frame(m2, 8'h11, 3, 0, 0, "R4", s, e);
  endtask

  task automatic test_cts();
    int m, s, e;
    cfg_cts_en = 1'b1;
    cts = 1'b0;
    m = log_n;
    write_char(8'hC3);
    wait_ticks(6);
    chk("R6", "held off by cts", count_val(m, 1'b0), 0);
    cts = 1'b1;
    wait_txd(1'b0);
    wait_ticks(2);
    cts = 1'b0;
    wait_empty();
    wait_ticks(2);
    check_frame(m, 8'hC3, 3, 0, 0, "R6", s, e);
    m = log_n;
    write_char(8'h24);
    wait_ticks(5);
    chk("R6", "second frame held", count_val(m, 1'b0), 0);
  endtask

  task automatic test_break();
    int mb, r, s, e;
    cmd(C_BRK);
    chk("R7", "break low without cts", int'(txd), 0);
    mb = log_n;
    wait_ticks(4);
    chk("R7", "break held across ticks", count_val(mb, 1'b1), 0);
    cmd(C_BRKSTOP);
    wait_txd(1'b1);
    r = log_n - 1;
    chk("R8", "release on a tick", int'(txd_log[r]), 1);
    chk("R8", "low at least one bit", int'(r - mb >= 1), 1);
    cts = 1'b1;
    wait_empty();
    wait_ticks(2);
    check_frame(r, 8'h24, 3, 0, 0, "R8", s, e);
    chk("R8", "mark before frame", int'(s > r), 1);
    cfg_cts_en = 1'b0;
  endtask

  initial begin
    tests = 0; fails = 0; log_n = 0; glitches = 0; done = 1'b0;
    rst_n = 1'b0; wr_stb = 0; wr_data = '0;
    cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
    cmd_brk_start = 0; cmd_brk_stop = 0; cmd_rts_on = 0;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop2 = 0; cfg_cts_en = 0; cfg_auto_rts = 0; cts = 1'b1;
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    cmd(C_EN);
    test_frame(8'hA5, 3, 0, 0);
    test_frame(8'hB6, 2, 1, 1);
    test_frame(8'hD3, 0, 2, 0);
    test_frame(8'h3C, 1, 1, 0);
    test_frame(8'h0F, 3, 3, 1);
    test_back_to_back();
    test_soft_reset();
    test_disable_rts();
    test_cts();
    test_break();
    chk("R11", "txd moved off-tick", glitches, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule